// File: doc/BRIEF.md
# Byte-Packed Ring Buffer over Word Storage

This block is a byte FIFO whose storage is a 32-bit-wide RAM. Four bytes share each storage word, so the RAM holds four times as many bytes as it has words. A producer pushes one byte per cycle. A consumer pops one byte per cycle and gets it back one cycle later. Two programmable settings place the ring inside the RAM: a word base address, and a top index that sets the highest byte index before the ring wraps.

Storing one byte means changing part of a word. The block reads the word that holds the byte, replaces one byte lane, and writes the whole word back. A two-state write pipeline spreads this over two cycles. The states are `WR_IDLE` (nothing pending) and `WR_COMMIT` (a merged word is being written):

- A push moves `WR_IDLE` to `WR_COMMIT`, or keeps the pipeline in `WR_COMMIT`.
- A cycle without a push returns `WR_COMMIT` to `WR_IDLE`, or leaves `WR_IDLE` where it is.

While a word is pending, both the next merge and the pop read take the pending word instead of the stale RAM word. When the ring is full, a new byte pushes the oldest byte out rather than being refused, and a sticky overrun flag records the loss.

Top module: `byte_ring_packed`

## Requirements
- R1: While reset is asserted and right after it, `empty` is 1, `overrun` is 0 and `pop_valid` is 0.
- R2: Bytes come out in the order they were pushed. A pop on a non-empty ring raises `pop_valid` on the next cycle, with the byte on `pop_data[7:0]`.
- R3: Byte index i is stored in lane i mod 4 of its word, with lane 0 at bits 7:0. A push rewrites only its own lane, so the bytes already in the other lanes of that word survive.
- R4: The head and tail indices each go back to zero after holding the value of `cfg_top`. A ring therefore has `cfg_top`+1 slots and holds at most `cfg_top` bytes.
- R5: `empty` is 1 exactly when head equals tail. A pop while empty is ignored: `pop_valid` stays 0 and the ring contents are unchanged.
- R6: A push into a full ring is accepted. The tail advances past the oldest byte, which is lost.
- R7: `overrun` goes to 1 when a byte is discarded and stays 1 until `overrun_clr` is asserted. If a discard and `overrun_clr` happen in the same cycle, `overrun` ends up 1.
- R8: A push and a pop in the same cycle both take effect. On a full ring this pair causes no discard and does not set `overrun`.
- R9: Back-to-back pushes into the same word, and a pop of a byte pushed in the previous cycle, return the right data while that word's write is still pending.
- R10: Byte index i lives in word `cfg_base` + i/4, with the sum taken modulo the RAM depth. The data that comes out does not depend on the base chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of indices, flags and pipeline |
| cfg_base | input | ADDR_W | Word address of byte index 0 |
| cfg_top | input | IDX_W | Highest byte index before wrap |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte, ignored while empty |
| overrun_clr | input | 1 | Clear the overrun flag |
| pop_valid | output | 1 | `pop_data` carries a popped byte this cycle |
| pop_data | output | 8 | Byte returned one cycle after an accepted pop |
| empty | output | 1 | Head equals tail |
| overrun | output | 1 | Sticky, a byte has been discarded |

## Verification
The bench builds the block with its default widths: 64 words of RAM and 8-bit byte indices. It then programs small values of `cfg_top` (6, 3 and 9), so that wrap, full-ring discard and push-pop on a full ring each take only a handful of pushes. A base of 1 places the ring in the middle of the RAM. A base of 62 makes the word address run off the end of the RAM and wrap to word 0. The pushes are spaced so that same-word merges and pops of just-pushed bytes land while a write is still pending.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [0:0] {
        WR_IDLE   = 1'b0,
        WR_COMMIT = 1'b1
    } wr_state_e;
endpackage

// File: rtl/bpk_ptrs.sv
module bpk_ptrs #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cfg_top,
    input  logic             push,
    input  logic             pop,
    input  logic             overrun_clr,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             pop_ok,
    output logic             empty,
    output logic             overrun
);
    logic [IDX_W-1:0] head_nx;
    logic [IDX_W-1:0] tail_after_pop;
    logic             drop;

    function automatic logic [IDX_W-1:0] adv(input logic [IDX_W-1:0] v,
                                             input logic [IDX_W-1:0] top);
        return (v >= top) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        empty          = (head == tail);
        pop_ok         = pop && !empty;
        head_nx        = adv(head, cfg_top);
        tail_after_pop = pop_ok ? adv(tail, cfg_top) : tail;
        drop           = push && (head_nx == tail_after_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            overrun <= 1'b0;
        end else begin
            if (push) head <= head_nx;
            tail <= drop ? adv(tail_after_pop, cfg_top) : tail_after_pop;
            if (drop)             overrun <= 1'b1;
            else if (overrun_clr) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/bpk_wordram.sv
module bpk_wordram #(
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [bpk_pkg::WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0]         raddr_a,
    output logic [bpk_pkg::WORD_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0]         raddr_b,
    output logic [bpk_pkg::WORD_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [bpk_pkg::WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bpk_rmw.sv
module bpk_rmw #(
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [bpk_pkg::LANE_W-1:0]        lane,
    input  logic [bpk_pkg::BYTE_W-1:0]        data,
    input  logic [bpk_pkg::WORD_W-1:0]        ram_word,
    output bpk_pkg::wr_state_e                state,
    output logic                              we,
    output logic [ADDR_W-1:0]                 waddr,
    output logic [bpk_pkg::WORD_W-1:0]        wdata
);
    import bpk_pkg::*;

    wr_state_e          state_nx;
    logic [ADDR_W-1:0]  pend_addr;
    logic [WORD_W-1:0]  pend_word;
    logic [WORD_W-1:0]  cur_word;
    logic [WORD_W-1:0]  merged;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE:   state_nx = push ? WR_COMMIT : WR_IDLE;
            WR_COMMIT: state_nx = push ? WR_COMMIT : WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        we    = (state == WR_COMMIT);
        waddr = pend_addr;
        wdata = pend_word;
    end

    // read phase: take the pending word if it is the one being modified
    assign cur_word = (we && pend_addr == addr) ? pend_word : ram_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(g)) ? data : cur_word[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_word <= '0;
        end else if (push) begin
            pend_addr <= addr;
            pend_word <= merged;
        end
    end
endmodule

// File: rtl/byte_ring_packed.sv
module byte_ring_packed #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_top,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic              pop,
    input  logic              overrun_clr,
    output logic              pop_valid,
    output logic [7:0]        pop_data,
    output logic              empty,
    output logic              overrun
);
    import bpk_pkg::*;

    localparam int LANE_SH = LANE_W;

    logic [IDX_W-1:0]  head_idx;
    logic [IDX_W-1:0]  tail_idx;
    logic              pop_ok;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [LANE_W-1:0] tail_lane;
    logic [WORD_W-1:0] ram_a;
    logic [WORD_W-1:0] ram_b;
    logic [WORD_W-1:0] pop_word;
    wr_state_e         wr_state;
    logic              wr_we;
    logic [ADDR_W-1:0] wr_waddr;
    logic [WORD_W-1:0] wr_wdata;

    bpk_ptrs #(.IDX_W(IDX_W)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_top     (cfg_top),
        .push        (push),
        .pop         (pop),
        .overrun_clr (overrun_clr),
        .head        (head_idx),
        .tail        (tail_idx),
        .pop_ok      (pop_ok),
        .empty       (empty),
        .overrun     (overrun)
    );

    assign wr_addr   = cfg_base + ADDR_W'(head_idx >> LANE_SH);
    assign rd_addr   = cfg_base + ADDR_W'(tail_idx >> LANE_SH);
    assign tail_lane = tail_idx[LANE_W-1:0];

    bpk_wordram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .we      (wr_we),
        .waddr   (wr_waddr),
        .wdata   (wr_wdata),
        .raddr_a (wr_addr),
        .rdata_a (ram_a),
        .raddr_b (rd_addr),
        .rdata_b (ram_b)
    );

    bpk_rmw #(.ADDR_W(ADDR_W)) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .addr     (wr_addr),
        .lane     (head_idx[LANE_W-1:0]),
        .data     (push_data),
        .ram_word (ram_a),
        .state    (wr_state),
        .we       (wr_we),
        .waddr    (wr_waddr),
        .wdata    (wr_wdata)
    );

    assign pop_word = (wr_we && wr_waddr == rd_addr) ? wr_wdata : ram_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= pop_ok;
            if (pop_ok) pop_data <= pop_word[{tail_lane, 3'b000} +: BYTE_W];
        end
    end
endmodule

// File: rtl/bpk_checker.sv
module bpk_checker #(
    parameter int IDX_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                push,
    input logic                pop,
    input logic                overrun_clr,
    input logic                pop_valid,
    input logic                empty,
    input logic                overrun,
    input logic [IDX_W-1:0]    head_idx,
    input logic [IDX_W-1:0]    cfg_top,
    input bpk_pkg::wr_state_e  wr_state
);
    a_r2_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(pop && !empty));

    a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && !pop_valid));

    a_r5_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);

    a_r6_overrun_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(push));

    a_r4_head_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        head_idx <= cfg_top);

    a_r9_commit_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == bpk_pkg::WR_COMMIT) |-> $past(push));
endmodule

bind byte_ring_packed bpk_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop         (pop),
    .overrun_clr (overrun_clr),
    .pop_valid   (pop_valid),
    .empty       (empty),
    .overrun     (overrun),
    .head_idx    (head_idx),
    .cfg_top     (cfg_top),
    .wr_state    (wr_state)
);

// File: tb/tb_byte_ring_packed.sv
module tb_byte_ring_packed;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 8;
    localparam int NV     = 30;

    // {push, pop, clr, data[7:0], exp_valid, exp_data[7:0], exp_empty, exp_overrun}
    localparam logic [21:0] VEC [NV] = '{
        {3'b100, 8'h11, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h22, 1'b0, 8'h00, 2'b00},  // R9 same-word merge
        {3'b100, 8'h33, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h44, 1'b0, 8'h00, 2'b00},  // R3 word now full
        {3'b010, 8'h00, 1'b1, 8'h11, 2'b00},
        {3'b110, 8'h55, 1'b1, 8'h22, 2'b00},  // R8
        {3'b010, 8'h00, 1'b1, 8'h33, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h44, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h55, 2'b10},
        {3'b010, 8'h00, 1'b0, 8'h00, 2'b10},  // R5 pop while empty
        {3'b100, 8'h60, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h61, 1'b0, 8'h00, 2'b00},  // R4 head wraps
        {3'b100, 8'h62, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h63, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h64, 1'b0, 8'h00, 2'b00},
        {3'b100, 8'h65, 1'b0, 8'h00, 2'b00},  // full
        {3'b100, 8'h66, 1'b0, 8'h00, 2'b01},  // R6 drops 60
        {3'b010, 8'h00, 1'b1, 8'h61, 2'b01},
        {3'b001, 8'h00, 1'b0, 8'h00, 2'b00},  // R7 clear
        {3'b010, 8'h00, 1'b1, 8'h62, 2'b00},
        {3'b110, 8'h7C, 1'b1, 8'h63, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h64, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h65, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h66, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'h7C, 2'b10},
        {3'b100, 8'hD0, 1'b0, 8'h00, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'hD0, 2'b10},  // R9 pop of pending byte
        {3'b100, 8'hD1, 1'b0, 8'h00, 2'b00},
        {3'b110, 8'hD2, 1'b1, 8'hD1, 2'b00},
        {3'b010, 8'h00, 1'b1, 8'hD2, 2'b10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [IDX_W-1:0]  cfg_top = 8'd6;
    logic              push = 1'b0;
    logic [7:0]        push_data = '0;
    logic              pop = 1'b0;
    logic              overrun_clr = 1'b0;
    logic              pop_valid;
    logic [7:0]        pop_data;
    logic              empty;
    logic              overrun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    byte_ring_packed #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_base    (cfg_base),
        .cfg_top     (cfg_top),
        .push        (push),
        .push_data   (push_data),
        .pop         (pop),
        .overrun_clr (overrun_clr),
        .pop_valid   (pop_valid),
        .pop_data    (pop_data),
        .empty       (empty),
        .overrun     (overrun)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic c, input logic [7:0] d);
        @(negedge clk);
        push = p; pop = q; overrun_clr = c; push_data = d;
        @(posedge clk);
        #(CLK_P/4);
        push = 1'b0; pop = 1'b0; overrun_clr = 1'b0;
    endtask

    task automatic do_reset(input logic [ADDR_W-1:0] b, input logic [IDX_W-1:0] t);
        @(negedge clk);
        rst_n = 1'b0; cfg_base = b; cfg_top = t;
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        chk("R1 empty in reset", 8'(empty), 8'd1);
        chk("R1 overrun in reset", 8'(overrun), 8'd0);
        chk("R1 pop_valid in reset", 8'(pop_valid), 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        step(1'b0, 1'b1, 1'b0, 8'h00);
        chk(tag, 8'(pop_valid), 8'd1);
        chk(tag, pop_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset, then the vector table (R2 R4 R5 R6 R7 R8 R9 R10 with base 1)
        do_reset(6'd1, 8'd6);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R1 empty after reset", 8'(empty), 8'd1);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
            chk("R2 pop_valid", 8'(pop_valid), 8'(VEC[i][10]));
            if (VEC[i][10]) chk("R2 R9 pop_data", pop_data, VEC[i][9:2]);
            chk("R5 empty", 8'(empty), 8'(VEC[i][1]));
            chk("R7 overrun", 8'(overrun), 8'(VEC[i][0]));
        end

        // R8: push and pop together on a full ring, no discard
        do_reset(6'd0, 8'd3);
        for (int i = 1; i <= 3; i++) step(1'b1, 1'b0, 1'b0, 8'(i));
        chk("R4 capacity reached without overrun", 8'(overrun), 8'd0);
        step(1'b1, 1'b1, 1'b0, 8'd4);
        chk("R8 pop_data", pop_data, 8'd1);
        chk("R8 no overrun", 8'(overrun), 8'd0);
        for (int i = 2; i <= 4; i++) pop_expect("R8 drain", 8'(i));
        chk("R5 empty after drain", 8'(empty), 8'd1);

        // R7: discard and clear in the same cycle leave overrun set
        for (int i = 5; i <= 7; i++) step(1'b1, 1'b0, 1'b0, 8'(i));
        step(1'b1, 1'b0, 1'b1, 8'd8);
        chk("R7 set wins over clear", 8'(overrun), 8'd1);
        for (int i = 6; i <= 8; i++) pop_expect("R6 oldest dropped", 8'(i));
        step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R7 still sticky", 8'(overrun), 8'd1);

        // R10: base near the RAM end, word address wraps past 63
        do_reset(6'd62, 8'd9);
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, 8'hA0 + 8'(i));
        for (int i = 0; i < 9; i++) pop_expect("R10 data at base 62", 8'hA0 + 8'(i));
        chk("R10 empty", 8'(empty), 8'd1);

        // R6: long overfill keeps only the newest nine bytes
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'hC0 + 8'(i));
        chk("R6 overrun after overfill", 8'(overrun), 8'd1);
        for (int i = 11; i < 20; i++) pop_expect("R6 newest kept", 8'hC0 + 8'(i));
        step(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R5 pop on empty ignored", 8'(pop_valid), 8'd0);
        chk("R5 still empty", 8'(empty), 8'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule